// File: doc/BRIEF.md
# Flash Write-Status Word Generator

This block forms the word a parallel NOR flash presents on its data pins while an internal program or erase is running, has been suspended, or has just finished. It follows the write activity through a small state machine, driven by one-cycle event pulses from the command decoder: program start, erase start, operation done, erase suspend and erase resume. From the current state it chooses between the array data and a status word. That word carries a polling bit, a main toggle bit and a secondary toggle bit.

The two toggle bits flip once at the end of each qualified read. A qualified read is a period in which both the active-low chip enable and the active-low output enable are held low. Toggle state never advances on the clock alone. The array contents, the command decoding and the address compare against the suspended sector are all supplied from outside. After a program completes, the block holds a settling window of `SETTLE_CYC` cycles. During that window only the polling bit shows true data, and the array is then passed through again.

The states are ST_READ (array pass-through), ST_PROG (program busy), ST_ERASE (erase busy), ST_SUSP (erase suspended), ST_SUSP_PROG (program while an erase is suspended) and ST_SETTLE (post-program settling). The transitions are:

- ST_READ to ST_PROG on program start.
- ST_READ to ST_ERASE on erase start.
- ST_PROG to ST_SETTLE on done.
- ST_SETTLE to ST_READ when the window expires.
- ST_ERASE to ST_READ on done.
- ST_ERASE to ST_SUSP on suspend.
- ST_SUSP to ST_ERASE on resume.
- ST_SUSP to ST_SUSP_PROG on program start.
- ST_SUSP_PROG to ST_SUSP on done.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset the block is in array pass-through: `dq` equals `array_q`, and both toggle bits start at 0.
- R2: While a program is busy (ST_PROG or ST_SUSP_PROG), `dq[7]` is the complement of the `prog_poll_bit` value captured when the program started. `dq[6]` and `dq[2]` show the toggle bits, and every other `dq` bit is 0.
- R3: While an erase is busy (ST_ERASE), `dq[7]` is 0, `dq[6]` and `dq[2]` show the toggle bits, and the other bits are 0.
- R4: The main toggle (`dq[6]`) inverts once at the end of each qualified read made while a program or erase is busy. It never changes in ST_READ, ST_SUSP or ST_SETTLE.
- R5: The secondary toggle (`dq[2]`) inverts at the end of each qualified read in ST_ERASE, and at the end of each qualified read in ST_SUSP that has `addr_in_susp` high. It holds its value during a program.
- R6: In ST_SUSP, a read with `addr_in_susp` high returns `dq[7]`=1, `dq[6]`=1 and `dq[2]` equal to the secondary toggle, with all other bits 0.
- R7: In ST_SUSP, a read with `addr_in_susp` low returns `array_q` unchanged.
- R8: A program start in ST_SUSP enters ST_SUSP_PROG, where the main toggle runs. On done the block returns to ST_SUSP, not to pass-through.
- R9: Done in ST_PROG opens a window of exactly `SETTLE_CYC` cycles. In this window `dq[7]` is the true captured bit, `dq[6]` and `dq[2]` hold their values, and the other bits are 0. Array pass-through follows the window.
- R10: Event collisions and ignored events:
  - In ST_ERASE, done takes priority over suspend.
  - In ST_SUSP, resume takes priority over program start.
  - In ST_READ, program start takes priority over erase start.
  - Any event that its state does not list is ignored.
- R11: A read is qualified only when `ce_n` and `oe_n` are both low. Asserting only one of them advances neither toggle bit.
- R12: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| start_prog | input | 1 | Pulse: internal program begins |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed, captured on start |
| start_erase | input | 1 | Pulse: internal erase begins |
| op_done | input | 1 | Pulse: current internal operation finished |
| erase_suspend | input | 1 | Pulse: suspend the running erase |
| erase_resume | input | 1 | Pulse: resume the suspended erase |
| addr_in_susp | input | 1 | Read address lies in the suspended sector or block |
| array_q | input | DW | Array data for the read address |
| dq | output | DW | Data word returned to the host |
| dq_oe | output | 1 | Output drive enable for the data pins |

## Verification
Two functions can coincide in one cycle: the end of a read, which advances the toggles, and a state change caused by done, suspend or resume. The bench provokes this by releasing a read in the same cycle that it pulses one of those events. It then expects the toggle step to follow the state that held before the edge.

Event pairs that collide are driven together in the same cycle: done with suspend, resume with program start, and program start with erase start. The next reads show which of each pair won.

Every cycle the bench compares `dq` and `dq_oe` against a model computed from the requirements. It sweeps both values of the captured bit, a changing array word, in-sector and out-of-sector suspended reads, and reads with only one of the two enables asserted.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP      = 3'd3,
        ST_SUSP_PROG = 3'd4,
        ST_SETTLE    = 3'd5
    } wsg_state_t;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int ALT_BIT  = 2;
endpackage

// File: rtl/wsg_fsm.sv
module wsg_fsm
    import wsg_pkg::*;
#(
    parameter int SETTLE_CYC = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_prog,
    input  logic       prog_poll_bit,
    input  logic       start_erase,
    input  logic       op_done,
    input  logic       erase_suspend,
    input  logic       erase_resume,
    output wsg_state_t state,
    output logic       poll_bit_q
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    wsg_state_t    state_nx;
    logic [CW-1:0] cnt_q;
    logic          take_prog;

    always_comb begin
        state_nx  = state;
        take_prog = 1'b0;
        unique case (state)
            ST_READ: begin
                if (start_prog) begin
                    state_nx  = ST_PROG;
                    take_prog = 1'b1;
                end else if (start_erase) begin
                    state_nx = ST_ERASE;
                end
            end
            ST_PROG:      if (op_done) state_nx = ST_SETTLE;
            ST_ERASE: begin
                if (op_done)            state_nx = ST_READ;
                else if (erase_suspend) state_nx = ST_SUSP;
            end
            ST_SUSP: begin
                if (erase_resume) begin
                    state_nx = ST_ERASE;
                end else if (start_prog) begin
                    state_nx  = ST_SUSP_PROG;
                    take_prog = 1'b1;
                end
            end
            ST_SUSP_PROG: if (op_done) state_nx = ST_SUSP;
            ST_SETTLE:    if (cnt_q == CNT_LAST) state_nx = ST_READ;
            default:      state_nx = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_READ;
            cnt_q      <= '0;
            poll_bit_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_prog) poll_bit_q <= prog_poll_bit;
            if (state == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    assert_done_beats_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && op_done) |=> (state == ST_READ));
    assert_resume_beats_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && erase_resume) |=> (state == ST_ERASE));
    assert_susp_prog_returns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP_PROG && op_done) |=> (state == ST_SUSP));
endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle
    import wsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  wsg_state_t state,
    input  logic       addr_in_susp,
    output logic       tog_main,
    output logic       tog_alt
);
    logic rd_now, rd_d, rd_end;
    logic main_run, alt_run;

    assign rd_now = ~ce_n & ~oe_n;
    assign rd_end = rd_d & ~rd_now;

    always_comb begin
        main_run = 1'b0;
        alt_run  = 1'b0;
        unique case (state)
            ST_PROG, ST_SUSP_PROG: main_run = 1'b1;
            ST_ERASE: begin
                main_run = 1'b1;
                alt_run  = 1'b1;
            end
            ST_SUSP:  alt_run = addr_in_susp;
            default: begin
                main_run = 1'b0;
                alt_run  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_d     <= 1'b0;
            tog_main <= 1'b0;
            tog_alt  <= 1'b0;
        end else begin
            rd_d <= rd_now;
            if (rd_end && main_run) tog_main <= ~tog_main;
            if (rd_end && alt_run)  tog_alt  <= ~tog_alt;
        end
    end

    assert_no_read_no_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_d) |=> ($stable(tog_main) && $stable(tog_alt)));
    assert_main_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_SUSP || state == ST_SETTLE) |=> $stable(tog_main));
endmodule

// File: rtl/wsg_outmux.sv
module wsg_outmux
    import wsg_pkg::*;
#(
    parameter int DW = 16
) (
    input  wsg_state_t    state,
    input  logic          poll_bit_q,
    input  logic          tog_main,
    input  logic          tog_alt,
    input  logic          addr_in_susp,
    input  logic [DW-1:0] array_q,
    output logic [DW-1:0] dq
);
    always_comb begin
        dq = '0;
        unique case (state)
            ST_READ: dq = array_q;
            ST_PROG, ST_SUSP_PROG: begin
                dq[POLL_BIT] = ~poll_bit_q;
                dq[TOG_BIT]  = tog_main;
                dq[ALT_BIT]  = tog_alt;
            end
            ST_ERASE: begin
                dq[POLL_BIT] = 1'b0;
                dq[TOG_BIT]  = tog_main;
                dq[ALT_BIT]  = tog_alt;
            end
            ST_SUSP: begin
                if (addr_in_susp) begin
                    dq[POLL_BIT] = 1'b1;
                    dq[TOG_BIT]  = 1'b1;
                    dq[ALT_BIT]  = tog_alt;
                end else begin
                    dq = array_q;
                end
            end
            ST_SETTLE: begin
                dq[POLL_BIT] = poll_bit_q;
                dq[TOG_BIT]  = tog_main;
                dq[ALT_BIT]  = tog_alt;
            end
            default: dq = array_q;
        endcase
    end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
    import wsg_pkg::*;
#(
    parameter int DW         = 16,
    parameter int SETTLE_CYC = 125
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          start_prog,
    input  logic          prog_poll_bit,
    input  logic          start_erase,
    input  logic          op_done,
    input  logic          erase_suspend,
    input  logic          erase_resume,
    input  logic          addr_in_susp,
    input  logic [DW-1:0] array_q,
    output logic [DW-1:0] dq,
    output logic          dq_oe
);
    wsg_state_t state;
    logic       poll_bit_q, tog_main, tog_alt;

    wsg_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_prog(start_prog), .prog_poll_bit(prog_poll_bit),
        .start_erase(start_erase), .op_done(op_done),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume),
        .state(state), .poll_bit_q(poll_bit_q)
    );

    wsg_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .state(state), .addr_in_susp(addr_in_susp),
        .tog_main(tog_main), .tog_alt(tog_alt)
    );

    wsg_outmux #(.DW(DW)) u_mux (
        .state(state), .poll_bit_q(poll_bit_q),
        .tog_main(tog_main), .tog_alt(tog_alt),
        .addr_in_susp(addr_in_susp), .array_q(array_q), .dq(dq)
    );

    assign dq_oe = ~ce_n & ~oe_n;

    assert_prog_poll_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG || state == ST_SUSP_PROG) |-> (dq[POLL_BIT] != poll_bit_q));
    assert_erase_poll_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> (dq[POLL_BIT] == 1'b0));
    assert_susp_sector_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && addr_in_susp) |-> (dq[POLL_BIT] && dq[TOG_BIT]));
    assert_settle_true_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE) |-> (dq[POLL_BIT] == poll_bit_q));
endmodule

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb;
    localparam int DW = 16;
    localparam int SC = 4;
    localparam int M_READ = 0, M_PROG = 1, M_ERASE = 2, M_SUSP = 3, M_SPROG = 4, M_SETTLE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic start_prog = 1'b0, prog_poll_bit = 1'b0, start_erase = 1'b0;
    logic op_done = 1'b0, erase_suspend = 1'b0, erase_resume = 1'b0;
    logic addr_in_susp = 1'b0;
    logic [DW-1:0] array_q = '0;
    logic [DW-1:0] dq;
    logic dq_oe;

    int n_vec = 0, n_bad = 0;
    int m_st = M_READ, m_cnt = 0, k = 0;
    logic m_t6 = 1'b0, m_t2 = 1'b0, m_w7 = 1'b0, m_rdd = 1'b0;

    always #4 clk = ~clk;

    flash_wstat_gen #(.DW(DW), .SETTLE_CYC(SC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .start_prog(start_prog), .prog_poll_bit(prog_poll_bit),
        .start_erase(start_erase), .op_done(op_done),
        .erase_suspend(erase_suspend), .erase_resume(erase_resume),
        .addr_in_susp(addr_in_susp), .array_q(array_q), .dq(dq), .dq_oe(dq_oe)
    );

    function automatic string req_of(int s);
        case (s)
            M_READ:   return "R1/R7 pass-through";
            M_PROG:   return "R2/R4 program";
            M_ERASE:  return "R3/R5 erase";
            M_SUSP:   return "R6/R7 suspend";
            M_SPROG:  return "R8 program in suspend";
            default:  return "R9 settle";
        endcase
    endfunction

    function automatic logic [DW-1:0] exp_dq();
        logic [DW-1:0] e = '0;
        case (m_st)
            M_READ: e = array_q;
            M_PROG, M_SPROG: begin e[7] = ~m_w7; e[6] = m_t6; e[2] = m_t2; end
            M_ERASE: begin e[7] = 1'b0; e[6] = m_t6; e[2] = m_t2; end
            M_SUSP: if (addr_in_susp) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = m_t2; end
                    else e = array_q;
            default: begin e[7] = m_w7; e[6] = m_t6; e[2] = m_t2; end
        endcase
        return e;
    endfunction

    task automatic check();
        logic [DW-1:0] e = exp_dq();
        logic eo = ~ce_n & ~oe_n;
        n_vec++;
        if (dq !== e) begin
            n_bad++;
            $display("FAIL %s: dq=%h expected %h (cycle %0d)", req_of(m_st), dq, e, k);
        end
        n_vec++;
        if (dq_oe !== eo) begin
            n_bad++;
            $display("FAIL R12: dq_oe=%b expected %b", dq_oe, eo);
        end
    endtask

    // model update at the clock edge from the inputs held across it
    task automatic tick();
        logic rd_now, rd_end;
        @(posedge clk);
        rd_now = ~ce_n & ~oe_n;
        rd_end = m_rdd & ~rd_now;
        m_rdd  = rd_now;
        if (rd_end && (m_st == M_PROG || m_st == M_ERASE || m_st == M_SPROG)) m_t6 = ~m_t6;
        if (rd_end && (m_st == M_ERASE || (m_st == M_SUSP && addr_in_susp))) m_t2 = ~m_t2;
        case (m_st)
            M_READ: if (start_prog) begin m_st = M_PROG; m_w7 = prog_poll_bit; end
                    else if (start_erase) m_st = M_ERASE;
            M_PROG: if (op_done) begin m_st = M_SETTLE; m_cnt = 0; end
            M_ERASE: if (op_done) m_st = M_READ; else if (erase_suspend) m_st = M_SUSP;
            M_SUSP: if (erase_resume) m_st = M_ERASE;
                    else if (start_prog) begin m_st = M_SPROG; m_w7 = prog_poll_bit; end
            M_SPROG: if (op_done) m_st = M_SUSP;
            default: if (m_cnt == SC - 1) m_st = M_READ; else m_cnt++;
        endcase
        @(negedge clk);
        check();
        k++;
        array_q = 16'(k * 16'h1357) ^ 16'hA5C3;
        start_prog = 0; start_erase = 0; op_done = 0; erase_suspend = 0; erase_resume = 0;
    endtask

    task automatic read_n(int n, int hold);
        for (int i = 0; i < n; i++) begin
            ce_n = 0; oe_n = 0;
            for (int h = 0; h < hold; h++) tick();
            ce_n = 1; oe_n = 1;
            tick();
        end
    endtask

    task automatic half_reads();   // R11: one enable only
        ce_n = 0; oe_n = 1; tick(); tick(); ce_n = 1; tick();
        oe_n = 0; tick(); tick(); oe_n = 1; tick();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check();                                   // R1 reset state
        rst_n = 1'b1;
        read_n(2, 1); half_reads();                // R1, R11 in pass-through

        for (int w = 0; w < 2; w++) begin          // R2, R4, R9
            prog_poll_bit = w[0]; start_prog = 1; start_erase = (w == 1); tick();  // R10 prog beats erase
            prog_poll_bit = ~w[0];
            read_n(3, 1 + w); half_reads();
            start_erase = 1; tick();               // R10 ignored while busy
            ce_n = 0; oe_n = 0; tick();
            ce_n = 1; oe_n = 1; op_done = 1; tick(); // read end with done, same cycle
            read_n(2, 1);                          // R9 settle reads
            for (int i = 0; i < SC; i++) tick();
            read_n(1, 1);
        end

        start_erase = 1; tick();                   // R3, R5
        read_n(3, 1); half_reads();
        op_done = 1; erase_suspend = 1; tick();    // R10 done beats suspend
        read_n(1, 1);

        start_erase = 1; tick();
        read_n(1, 1);
        ce_n = 0; oe_n = 0; tick();
        ce_n = 1; oe_n = 1; erase_suspend = 1; tick();
        for (int a = 0; a < 4; a++) begin          // R6, R7, R5 in suspend
            addr_in_susp = a[0]; read_n(2, 1); half_reads();
        end
        addr_in_susp = 1;
        erase_resume = 1; start_prog = 1; tick();  // R10 resume beats program
        read_n(2, 1);
        erase_suspend = 1; tick();
        prog_poll_bit = 1; start_prog = 1; tick(); // R8
        for (int a = 0; a < 2; a++) begin addr_in_susp = a[0]; read_n(2, 1); end
        op_done = 1; tick();
        addr_in_susp = 1; read_n(2, 1);
        addr_in_susp = 0; read_n(1, 1);
        erase_resume = 1; tick();
        read_n(2, 1);
        op_done = 1; tick();
        read_n(2, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule